// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block is a management-bus master for Ethernet PHYs. Software reaches it through a small 32-bit register port. It first sets a clock prescaler. It then posts one packed command word that selects a read or a write and carries the PHY address, the register address and the write data. The block turns that word into a complete Clause 22 management frame on MDC and MDIO. When a read ends, it stores the returned value, together with an error indication, in a data register.

Two status flags let software pace its accesses. The first, "queued", is set while an accepted command is waiting for the bus. The second, "active", is set while a frame is being shifted. A new command may be posted while a frame is running. It waits and starts as soon as that frame ends. A command posted while another one is still queued is dropped. MDC runs only during a frame and rests low between frames.

Top module: `mdio_master`

## Requirements
- R1: After reset, status (byte offset 0x0) reads 0, the data register (0xC) reads 0, the configuration register (0x10) reads 1, MDC is low and MDIO output-enable is low.
- R2: Configuration bits 7:0 hold a prescale value P. During a frame, MDC has a period of 2×(P+1) system clocks. A configuration write whose bits 7:0 are zero leaves the stored value unchanged.
- R3: A write to the command register (0x8) is accepted only if bit 31 (valid) is 1, status bit 2 is clear, and bit 2 (read) or bit 1 (write) is set. Bit 2 takes priority when both op bits are set. A command with valid clear, or with neither op bit set, starts no frame and leaves status at 0.
- R4: Status bit 2 (queued) is set from acceptance until the frame starts. A command written while it is set is ignored. The command register reads back the stored word, and its bit 31 clears when the frame starts. A command accepted during a frame starts only after that frame ends.
- R5: Status bit 3 (active) is set from frame start to the last MDC falling edge. While it is clear, MDC and MDIO output-enable are low.
- R6: Each frame carries, MSB first, 32 ones, then 01, then the opcode (10 read, 01 write), then the PHY address from command bits 29:25 and the register address from bits 24:20. A write continues with the turnaround 10 and then command bits 19:4.
- R7: On a read, the master releases MDIO (output-enable low) from the first turnaround bit to the end of the frame. It samples bits 48 to 63 of the frame into data register bits 15:0, MSB first.
- R8: If MDIO is high at the rising MDC edge of the second turnaround bit of a read, data bits 17:16 read 11; otherwise they read 00. The data register is loaded only when a read completes, and writes leave it unchanged.
- R9: MDIO output and output-enable change only at MDC falling edges or at frame start while MDC is low. They never change while MDC is high, and never on a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The bench posts a write frame, then queues a read behind it while the write is still running, then tries a third command that must be dropped. This shows that queuing and dropping are separate cases. A model PHY returns chosen data with a good turnaround, and later with a bad one. This separates a correct data capture from error reporting. The bench also posts a command with both op bits set, to show read priority. Frames at two prescale values show that the MDC period follows the configuration. Commands with valid clear, or with no op bit, must start no frame, and a later write must not disturb the stored read result.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int BUS_W   = 32;
    localparam int DATA_W  = 16;
    localparam int FIELD_W = 5;

    localparam logic [4:0] OFS_STATUS = 5'h00;
    localparam logic [4:0] OFS_CMD    = 5'h08;
    localparam logic [4:0] OFS_DATA   = 5'h0C;
    localparam logic [4:0] OFS_CFG    = 5'h10;

    localparam int CMD_VALID_BIT = 31;
    localparam int CMD_PHY_LSB   = 25;
    localparam int CMD_REG_LSB   = 20;
    localparam int CMD_WD_LSB    = 4;
    localparam int CMD_RD_BIT    = 2;
    localparam int CMD_WR_BIT    = 1;

    localparam int ST_QUEUED_BIT = 2;
    localparam int ST_ACTIVE_BIT = 3;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == presc);
        cnt_d = cnt_q + 1'b1;
        if (!en || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine #(
    parameter int PRE_LEN = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             start_rd,
    input  logic [PRE_LEN+31:0]              frame,
    input  logic                             tick,
    input  logic                             mdio_i,
    output logic                             busy,
    output logic                             mdc,
    output logic                             mdio_o,
    output logic                             mdio_oe,
    output logic                             fin,
    output logic                             fin_rd,
    output logic [mdio_pkg::DATA_W-1:0]      rd_data,
    output logic                             rd_err
);
    localparam int FRAME_LEN = PRE_LEN + 32;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(PRE_LEN + 14);
    localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(PRE_LEN + 15);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_LEN + 16);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic                        busy;
        logic                        mdc;
        logic                        rd;
        logic                        oe;
        logic                        out;
        logic [IDX_W-1:0]            idx;
        logic [FRAME_LEN-1:0]        sh;
        logic [mdio_pkg::DATA_W-1:0] cap;
        logic                        taerr;
    } eng_t;

    eng_t e_d, e_q;
    logic [IDX_W-1:0] nidx;

    always_comb begin
        e_d  = e_q;
        fin  = 1'b0;
        nidx = e_q.idx + 1'b1;
        if (!e_q.busy) begin
            if (start) begin
                e_d.busy  = 1'b1;
                e_d.mdc   = 1'b0;
                e_d.rd    = start_rd;
                e_d.idx   = '0;
                e_d.sh    = frame;
                e_d.out   = frame[FRAME_LEN-1];
                e_d.oe    = 1'b1;
                e_d.cap   = '0;
                e_d.taerr = 1'b0;
            end
        end else if (tick) begin
            if (!e_q.mdc) begin
                e_d.mdc = 1'b1;
                if (e_q.rd && e_q.idx == TA2_IDX) e_d.taerr = mdio_i;
                if (e_q.rd && e_q.idx >= DAT_IDX)
                    e_d.cap = {e_q.cap[mdio_pkg::DATA_W-2:0], mdio_i};
            end else begin
                e_d.mdc = 1'b0;
                if (e_q.idx == LAST_IDX) begin
                    fin      = 1'b1;
                    e_d.busy = 1'b0;
                    e_d.oe   = 1'b0;
                    e_d.out  = 1'b1;
                end else begin
                    e_d.idx = nidx;
                    e_d.sh  = {e_q.sh[FRAME_LEN-2:0], 1'b0};
                    e_d.out = e_q.sh[FRAME_LEN-2];
                    e_d.oe  = !(e_q.rd && nidx >= TA1_IDX);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q     <= '0;
            e_q.out <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy    = e_q.busy;
    assign mdc     = e_q.mdc;
    assign mdio_o  = e_q.out;
    assign mdio_oe = e_q.oe;
    assign fin_rd  = e_q.rd;
    assign rd_data = e_q.cap;
    assign rd_err  = e_q.taerr;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int PRESC_W = 8,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int FRAME_LEN = PRE_LEN + 32;

    typedef struct packed {
        logic [BUS_W-1:0]   cmd;
        logic               queued;
        logic [PRESC_W-1:0] presc;
        logic [DATA_W-1:0]  data;
        logic [1:0]         err;
    } regs_t;

    regs_t r_d, r_q;

    logic                 eng_busy, eng_fin, eng_fin_rd, eng_err, tick;
    logic [DATA_W-1:0]    eng_data;
    logic                 start, accept, cmd_rd, queued_w;
    logic                 wr_cmd, wr_cfg;
    logic [FRAME_LEN-1:0] frame;

    assign wr_cmd = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
    assign wr_cfg = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
    assign accept = wr_cmd && bus_wdata[CMD_VALID_BIT] && !r_q.queued &&
                    (bus_wdata[CMD_RD_BIT] || bus_wdata[CMD_WR_BIT]);
    assign start  = r_q.queued && !eng_busy;
    assign cmd_rd = r_q.cmd[CMD_RD_BIT];
    assign queued_w = r_q.queued;

    always_comb begin
        frame = {{PRE_LEN{1'b1}}, 2'b01,
                 (cmd_rd ? 2'b10 : 2'b01),
                 r_q.cmd[CMD_PHY_LSB +: FIELD_W],
                 r_q.cmd[CMD_REG_LSB +: FIELD_W],
                 (cmd_rd ? 2'b11 : 2'b10),
                 (cmd_rd ? {DATA_W{1'b1}} : r_q.cmd[CMD_WD_LSB +: DATA_W])};
    end

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.queued             = 1'b0;
            r_d.cmd[CMD_VALID_BIT] = 1'b0;
        end
        if (accept) begin
            r_d.cmd    = bus_wdata;
            r_d.queued = 1'b1;
        end
        if (wr_cfg && (bus_wdata[PRESC_W-1:0] != '0))
            r_d.presc = bus_wdata[PRESC_W-1:0];
        if (eng_fin && eng_fin_rd) begin
            r_d.data = eng_data;
            r_d.err  = {2{eng_err}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.presc <= PRESC_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == ADDR_W'(OFS_STATUS)) begin
                bus_rdata[ST_QUEUED_BIT] = r_q.queued;
                bus_rdata[ST_ACTIVE_BIT] = eng_busy;
            end else if (bus_addr == ADDR_W'(OFS_CMD)) begin
                bus_rdata = r_q.cmd;
            end else if (bus_addr == ADDR_W'(OFS_DATA)) begin
                bus_rdata[DATA_W-1:0]      = r_q.data;
                bus_rdata[DATA_W+1:DATA_W] = r_q.err;
            end else if (bus_addr == ADDR_W'(OFS_CFG)) begin
                bus_rdata[PRESC_W-1:0] = r_q.presc;
            end
        end
    end

    mdio_clkgen #(.PRESC_W(PRESC_W)) i_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (eng_busy),
        .presc (r_q.presc),
        .tick  (tick)
    );

    mdio_engine #(.PRE_LEN(PRE_LEN)) i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_rd (cmd_rd),
        .frame    (frame),
        .tick     (tick),
        .mdio_i   (mdio_i),
        .busy     (eng_busy),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .fin      (eng_fin),
        .fin_rd   (eng_fin_rd),
        .rd_data  (eng_data),
        .rd_err   (eng_err)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic queued,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    // R4: a queued command starts on the next edge once the bus is free
    a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
        queued && !busy |=> busy && !queued);

    // R4: a queued command keeps waiting while a frame runs
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        queued && busy |=> queued);

    // R5: clock and driver idle outside a frame
    a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc && !mdio_oe);

    // R6: a frame begins with the master driving and MDC low
    a_r6_begin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mdio_oe && !mdc);

    // R9: no MDIO change while MDC stays high
    a_r9_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        mdc && $past(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));

    // R9: no MDIO change on a rising MDC edge
    a_r9_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));
endmodule

bind mdio_master mdio_master_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (eng_busy),
    .queued  (queued_w),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_in;

    always #5 clk = ~clk;

    mdio_master i_mdio_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_in)
    );

    typedef struct {
        logic [63:0] bits;
        logic [63:0] mask;
        longint      period;
    } item_t;

    item_t sb[$];

    int nchk = 0, nerr = 0;
    int mchk = 0, merr = 0;
    int r9viol = 0;
    bit finished = 1'b0;

    logic [15:0] phy_val = 16'h0;
    logic        phy_ta2 = 1'b0;
    int          rcount = 0;

    // model PHY: presents the bit for the next rising MDC edge
    always_comb begin
        if (rcount == 47)                      mdio_in = phy_ta2;
        else if (rcount >= 48 && rcount <= 63) mdio_in = phy_val[63 - rcount];
        else                                   mdio_in = 1'b1;
    end

    // monitor: captures each frame at MDC rising edges and compares it
    item_t       cur;
    bit          have = 1'b0;
    int          perbad = 0;
    longint      last_rise = 0;
    logic [63:0] cap_o, cap_oe;

    always @(posedge mdc) begin
        if (rcount == 0) begin
            perbad = 0;
            if (sb.size() == 0) begin
                have = 1'b0;
                mchk++; merr++;
                $display("FAIL R3: unexpected frame, actual=1 expected=0");
            end else begin
                cur  = sb.pop_front();
                have = 1'b1;
            end
        end else if (($time - last_rise) != cur.period) begin
            perbad++;
        end
        last_rise = $time;
        cap_o[63 - rcount]  = mdio_o;
        cap_oe[63 - rcount] = mdio_oe;
        if (rcount == 63) begin
            rcount = 0;
            if (have) begin
                mchk++;
                if ((cap_o & cur.mask) !== (cur.bits & cur.mask)) begin
                    merr++;
                    $display("FAIL R6: frame actual=%h expected=%h",
                             cap_o & cur.mask, cur.bits & cur.mask);
                end
                mchk++;
                if (cap_oe !== cur.mask) begin
                    merr++;
                    $display("FAIL R7: enable actual=%h expected=%h", cap_oe, cur.mask);
                end
                mchk++;
                if (perbad != 0) begin
                    merr++;
                    $display("FAIL R2: MDC period errors actual=%0d expected=0", perbad);
                end
            end
        end else begin
            rcount++;
        end
    end

    // R9 watcher: sampled away from the active edge
    logic p_mdc = 1'b0, p_o = 1'b1, p_oe = 1'b0;
    always @(negedge clk) begin
        if (mdc && p_mdc && (mdio_o !== p_o || mdio_oe !== p_oe)) r9viol++;
        p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] cmd_word(logic v, logic rd, logic wr,
                                             logic [4:0] phy, logic [4:0] rg,
                                             logic [15:0] wd);
        return {v, 1'b0, phy, rg, wd, 1'b0, rd, wr, 1'b0};
    endfunction

    // driver: queue the expected frame for one command
    task automatic expect_frame(logic rd, logic [4:0] phy, logic [4:0] rg,
                                logic [15:0] wd, int presc);
        item_t it;
        it.bits   = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                     (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
        it.mask   = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        it.period = 20 * (presc + 1);
        sb.push_back(it);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 4000; k++) begin
            bus_read(5'h00, s);
            if (s == 32'h0) return;
        end
    endtask

    logic [31:0] v;

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(5'h00, v); chk("R1 status", v, 0);
        bus_read(5'h0C, v); chk("R1 data", v, 0);
        bus_read(5'h10, v); chk("R1 config", v, 1);
        chk("R1 mdc/oe", {mdc, mdio_oe}, 0);

        // R2 zero prescale ignored
        bus_write(5'h10, 32'h0);
        bus_read(5'h10, v); chk("R2 zero prescale ignored", v, 1);

        // write frame, P=1
        expect_frame(1'b0, 5'h13, 5'h0A, 16'hA5C3, 1);
        bus_write(5'h08, cmd_word(1, 0, 1, 5'h13, 5'h0A, 16'hA5C3));
        bus_read(5'h00, v); chk("R5 active, R4 queued cleared", v, 32'h8);
        bus_read(5'h08, v); chk("R4 valid bit cleared at start", v,
                                cmd_word(0, 0, 1, 5'h13, 5'h0A, 16'hA5C3));

        // read queued behind the running write
        phy_val = 16'h3C96; phy_ta2 = 1'b0;
        expect_frame(1'b1, 5'h01, 5'h1F, 16'h0, 1);
        bus_write(5'h08, cmd_word(1, 1, 0, 5'h01, 5'h1F, 16'h0));
        bus_read(5'h00, v); chk("R4 queued while active", v, 32'hC);
        bus_write(5'h08, cmd_word(1, 0, 1, 5'h07, 5'h03, 16'h1234));
        bus_read(5'h08, v); chk("R4 command while queued ignored", v,
                                cmd_word(1, 1, 0, 5'h01, 5'h1F, 16'h0));
        wait_idle();
        bus_read(5'h0C, v); chk("R7 read data", v, 32'h0000_3C96);

        // R2 new prescale, R3 read priority, R8 turnaround error
        bus_write(5'h10, 32'h3);
        bus_read(5'h10, v); chk("R2 prescale stored", v, 3);
        phy_val = 16'h8001; phy_ta2 = 1'b1;
        expect_frame(1'b1, 5'h1C, 5'h02, 16'h0, 3);
        bus_write(5'h08, cmd_word(1, 1, 1, 5'h1C, 5'h02, 16'hFFFF));
        wait_idle();
        bus_read(5'h0C, v); chk("R8 error field", v, 32'h0003_8001);

        // R3 rejected commands
        bus_write(5'h08, cmd_word(0, 0, 1, 5'h02, 5'h04, 16'h5555));
        bus_read(5'h00, v); chk("R3 valid clear ignored", v, 0);
        bus_write(5'h08, cmd_word(1, 0, 0, 5'h02, 5'h04, 16'h5555));
        bus_read(5'h00, v); chk("R3 no op bit ignored", v, 0);
        repeat (50) @(posedge clk);

        // R8 a write leaves the data register alone
        expect_frame(1'b0, 5'h0F, 5'h11, 16'h0FF0, 3);
        bus_write(5'h08, cmd_word(1, 0, 1, 5'h0F, 5'h11, 16'h0FF0));
        wait_idle();
        bus_read(5'h0C, v); chk("R8 data kept after write", v, 32'h0003_8001);
        chk("R5 idle after frame", {mdc, mdio_oe}, 0);

        repeat (600) @(posedge clk);
        chk("R6 all frames seen", sb.size(), 0);
        chk("R9 MDIO stable while MDC high", r9viol, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr + merr, nchk + mchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", nerr + merr + 1, nchk + mchk + 1);
            $finish;
        end
    end
endmodule